// File: doc/BRIEF.md
# Keyed Serial Clock Access Port

This block sits between a host memory bus and the chip enable of an SRAM. It carries no address decode. It watches every bus cycle through three active-low strobes that are already synchronised to the system clock: chip enable in, output enable and write enable. A bus cycle begins on the first clock at which chip enable in is low together with at least one of the other two strobes. A cycle with write enable low is a write. A cycle with output enable low and write enable high is a read. While the port is locked, every cycle reaches the memory, because the chip-enable output simply follows chip enable in.

To unlock the port, the host issues one read and then 64 writes. Each write carries one bit of a fixed 64-bit key on the serial data input. The key is the byte sequence C5, 3A, A3, 5C, sent twice, with each byte sent least significant bit first. Once all 64 bits have matched, the next 64 bus cycles go to the eight clock registers instead of the memory, and the memory stays deselected for all of them. Each of those cycles moves one bit. A write cycle takes its bit from the data input. A read cycle returns its bit on the data output. The bits run from register 0 bit 0 up to register 7 bit 7. Written bits are gathered and handed to the clock one whole byte at a time. A read returns a copy of the registers that was captured when the key completed.

Two outputs carry data out of the block: the byte-commit stream (`wr_valid`, `wr_idx`, `wr_data`) and the read-bit stream (`dout_valid`, `dout`). Both are valid-only. A bus cycle cannot be stalled, so the consumer has no back-pressure and must accept every beat in the cycle it is offered. Each beat lasts exactly one clock.

Top module: `keyed_clock_port`

## Requirements
- R1: While locked and with no power fail, `ce_out_n` equals `cs_in_n`. Every bus cycle therefore reaches the memory, including the unlock read and the 64 key writes.
- R2: A read cycle while locked returns the key pointer to bit 0 and clears any recorded mismatch. A fresh 64-bit key sent after a read unlocks the port, even when the read arrived part-way through an earlier key.
- R3: If a key write's bit differs from the key bit at the pointer, the pointer freezes. Every later write is then ignored until a read occurs, so completing the rest of the key does not unlock the port.
- R4: After all 64 key bits match (key 64'h5CA33AC55CA33AC5, bit 0 sent first), the next 64 bus cycles are clock transfers. During each of them, `ce_out_n` stays 1 even while `cs_in_n` is 0.
- R5: Write transfers fill register k with bit j in transfer cycle 8k+j, least significant bit first. When bit 7 arrives, one `wr_valid` pulse carries `wr_idx`=k and the full byte on `wr_data`.
- R6: Each read transfer gives one `dout_valid` pulse. Its `dout` is bit 8k+j of `time_in` as sampled when the key completed, so later changes on `time_in` do not affect the data read out.
- R7: Strobe activity with `cs_in_n` high is not a bus cycle. It leaves both the key match and the transfer position unchanged.
- R8: When `time_in` bit 36 (register 4, bit 4) is 0, a low on `rst_in_n` aborts the sequence and the port relocks. When that bit is 1, `rst_in_n` is ignored.
- R9: While `power_fail` is 1, `ce_out_n` is 1, any transfer is aborted, and bus cycles have no effect. Once it clears, the port is locked with the pointer at 0.
- R10: A byte is committed only if all eight of its transfer cycles were writes. A partial byte cut off by an abort is dropped, and so is a byte that mixed reads and writes.
- R11: After the 64th transfer cycle the port relocks: `ce_out_n` follows `cs_in_n` again, and the full key is needed for the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| cs_in_n | input | 1 | Bus chip enable in, active low |
| oe_n | input | 1 | Bus output enable, active low |
| we_n | input | 1 | Bus write enable, active low |
| din | input | 1 | Serial data input bit |
| rst_in_n | input | 1 | Abort request, active low, maskable |
| power_fail | input | 1 | Supply-failure indication, active high |
| time_in | input | 64 | Current clock registers, register k in bits 8k+7..8k |
| ce_out_n | output | 1 | Chip enable to the memory, active low |
| dout | output | 1 | Serial data output bit |
| dout_valid | output | 1 | One-clock pulse marking a valid `dout` |
| wr_valid | output | 1 | One-clock pulse marking a committed byte |
| wr_idx | output | 3 | Register number of the committed byte |
| wr_data | output | 8 | Committed byte value |

## Verification
The bench aims at the points where a design can drift from the key rules:
- A bad bit in the middle of the key, with the rest of the key then sent correctly. A design that only resynchronises its pointer would unlock here.
- A read arriving part-way through the key. A design that does not reset its pointer would reject the next full key.
- A byte that mixes reads and writes, and aborts raised by reset and by power fail in the middle of a byte. A design that commits on position alone would emit corrupt bytes.
- A change on `time_in` after unlock. A design without the snapshot would return the new bits instead of the captured ones.
- Deselected strobe activity and masked resets scattered through the sequences. A design that counts these would slip its bit position or drop the transfer.

// File: rtl/kcp_pkg.sv
package kcp_pkg;
  typedef enum logic [1:0] {
    CYC_NONE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;

  localparam int BYTE_W  = 8;
  localparam int BIT_SEL = 3;
endpackage

// File: rtl/kcp_strobe_decode.sv
module kcp_strobe_decode
  import kcp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic din,
  input  logic block,
  output cyc_e ev,
  output logic ev_bit
);
  logic active;
  logic active_q;

  // a bus cycle is any stretch with chip select and one strobe low
  assign active = !cs_n && (!oe_n || !we_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ev       <= CYC_NONE;
      ev_bit   <= 1'b0;
    end else begin
      active_q <= active;
      ev_bit   <= din;
      if (active && !active_q && !block)
        ev <= (!we_n) ? CYC_WRITE : CYC_READ;
      else
        ev <= CYC_NONE;
    end
  end
endmodule

// File: rtl/kcp_key_match.sv
module kcp_key_match
  import kcp_pkg::*;
#(
  parameter int          KEY_W = 64,
  parameter logic [KEY_W-1:0] KEY = '0,
  localparam int         PW    = $clog2(KEY_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_e          ev,
  input  logic          ev_bit,
  input  logic          hold,
  input  logic          abort,
  output logic [PW-1:0] ptr,
  output logic          miss,
  output logic          unlock
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      miss   <= 1'b0;
      unlock <= 1'b0;
    end else begin
      unlock <= 1'b0;
      if (abort) begin
        ptr  <= '0;
        miss <= 1'b0;
      end else if (!hold) begin
        case (ev)
          CYC_READ: begin
            ptr  <= '0;
            miss <= 1'b0;
          end
          CYC_WRITE: begin
            if (!miss) begin
              if (ev_bit == KEY[ptr]) begin
                if (ptr == PW'(KEY_W - 1)) begin
                  ptr    <= '0;
                  unlock <= 1'b1;
                end else begin
                  ptr <= ptr + 1'b1;
                end
              end else begin
                miss <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/kcp_xfer_engine.sv
module kcp_xfer_engine
  import kcp_pkg::*;
#(
  parameter int  REG_BYTES = 8,
  localparam int NB    = REG_BYTES * BYTE_W,
  localparam int PW    = $clog2(NB),
  localparam int IDX_W = PW - BIT_SEL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_e              ev,
  input  logic              ev_bit,
  input  logic              unlock,
  input  logic              abort,
  input  logic [NB-1:0]     time_in,
  output logic              busy,
  output logic              dout,
  output logic              dout_valid,
  output logic              wr_valid,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data
);
  logic [PW-1:0]     xptr;
  logic [BYTE_W-1:0] acc;
  logic              all_wr;
  logic [NB-1:0]     snap;

  logic              is_wr;
  logic              step;
  logic              all_wr_nx;
  logic [BYTE_W-1:0] acc_nx;
  logic              byte_end;

  always_comb begin
    step      = busy && (ev != CYC_NONE);
    is_wr     = (ev == CYC_WRITE);
    all_wr_nx = ((xptr[BIT_SEL-1:0] == '0) ? 1'b1 : all_wr) && is_wr;
    acc_nx    = {ev_bit && is_wr, acc[BYTE_W-1:1]};
    byte_end  = (xptr[BIT_SEL-1:0] == {BIT_SEL{1'b1}});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      xptr       <= '0;
      acc        <= '0;
      all_wr     <= 1'b0;
      snap       <= '0;
      dout       <= 1'b0;
      dout_valid <= 1'b0;
      wr_valid   <= 1'b0;
      wr_idx     <= '0;
      wr_data    <= '0;
    end else begin
      dout_valid <= 1'b0;
      wr_valid   <= 1'b0;
      if (abort) begin
        busy   <= 1'b0;
        xptr   <= '0;
        acc    <= '0;
        all_wr <= 1'b0;
      end else if (unlock) begin
        busy   <= 1'b1;
        xptr   <= '0;
        acc    <= '0;
        all_wr <= 1'b0;
        snap   <= time_in;
      end else if (step) begin
        acc    <= acc_nx;
        all_wr <= all_wr_nx;
        if (!is_wr) begin
          dout       <= snap[xptr];
          dout_valid <= 1'b1;
        end
        if (byte_end && all_wr_nx) begin
          wr_valid <= 1'b1;
          wr_idx   <= xptr[PW-1:BIT_SEL];
          wr_data  <= acc_nx;
        end
        if (xptr == PW'(NB - 1)) begin
          busy <= 1'b0;
          xptr <= '0;
        end else begin
          xptr <= xptr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/keyed_clock_port.sv
module keyed_clock_port
  import kcp_pkg::*;
#(
  parameter int  REG_BYTES    = 8,
  parameter logic [REG_BYTES*8-1:0] KEY = 64'h5CA3_3AC5_5CA3_3AC5,
  parameter int  RST_MASK_BIT = 36,
  localparam int NB    = REG_BYTES * BYTE_W,
  localparam int PW    = $clog2(NB),
  localparam int IDX_W = PW - BIT_SEL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_in_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              din,
  input  logic              rst_in_n,
  input  logic              power_fail,
  input  logic [NB-1:0]     time_in,
  output logic              ce_out_n,
  output logic              dout,
  output logic              dout_valid,
  output logic              wr_valid,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data
);
  cyc_e          ev;
  logic          ev_bit;
  logic          abort;
  logic          busy;
  logic          unlock;
  logic          hold;
  logic [PW-1:0] key_ptr;
  logic          key_miss;

  assign abort = power_fail || (!rst_in_n && !time_in[RST_MASK_BIT]);
  assign hold  = busy || unlock;

  kcp_strobe_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_in_n),
    .oe_n   (oe_n),
    .we_n   (we_n),
    .din    (din),
    .block  (abort),
    .ev     (ev),
    .ev_bit (ev_bit)
  );

  kcp_key_match #(.KEY_W(NB), .KEY(KEY)) u_key (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (ev),
    .ev_bit (ev_bit),
    .hold   (hold),
    .abort  (abort),
    .ptr    (key_ptr),
    .miss   (key_miss),
    .unlock (unlock)
  );

  kcp_xfer_engine #(.REG_BYTES(REG_BYTES)) u_xfer (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev         (ev),
    .ev_bit     (ev_bit),
    .unlock     (unlock),
    .abort      (abort),
    .time_in    (time_in),
    .busy       (busy),
    .dout       (dout),
    .dout_valid (dout_valid),
    .wr_valid   (wr_valid),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data)
  );

  assign ce_out_n = cs_in_n || busy || power_fail;
endmodule

// File: rtl/kcp_checker.sv
module kcp_checker
  import kcp_pkg::*;
#(
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          power_fail,
  input logic          busy,
  input logic          unlock,
  input logic          hold,
  input logic          abort,
  input cyc_e          ev,
  input logic [PW-1:0] key_ptr,
  input logic          key_miss,
  input logic          wr_valid,
  input logic          dout_valid
);
  // R2: a read while locked sends the pointer back to bit 0
  a_r2_read_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == CYC_READ && !hold && !abort) |=> (key_ptr == '0));

  // R3: once a mismatch is recorded, writes do not move the pointer
  a_r3_miss_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (key_miss && ev == CYC_WRITE && !hold && !abort) |=> $stable(key_ptr));

  // R4: a completed key opens the transfer window
  a_r4_unlock_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock && !abort) |=> busy);

  // R5: bytes are committed only by transfer cycles
  a_r5_commit_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(busy));

  // R6: read bits are produced only by transfer cycles
  a_r6_read_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> $past(busy));

  // R9: power fail closes the window and rewinds the key
  a_r9_pf_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    power_fail |=> (!busy && key_ptr == '0 && !key_miss));
endmodule

bind keyed_clock_port kcp_checker #(.PW(PW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .power_fail (power_fail),
  .busy       (busy),
  .unlock     (unlock),
  .hold       (hold),
  .abort      (abort),
  .ev         (ev),
  .key_ptr    (key_ptr),
  .key_miss   (key_miss),
  .wr_valid   (wr_valid),
  .dout_valid (dout_valid)
);

// File: tb/keyed_clock_port_test.sv
module keyed_clock_port_test;
  localparam logic [63:0] KEY = 64'h5CA3_3AC5_5CA3_3AC5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_in_n = 1'b1;
  logic        oe_n = 1'b1;
  logic        we_n = 1'b1;
  logic        din = 1'b0;
  logic        rst_in_n = 1'b1;
  logic        power_fail = 1'b0;
  logic [63:0] time_in = '0;
  logic        ce_out_n;
  logic        dout;
  logic        dout_valid;
  logic        wr_valid;
  logic [2:0]  wr_idx;
  logic [7:0]  wr_data;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic [10:0] exp_wr[$];
  logic        exp_rd[$];

  always #10 clk = ~clk;

  keyed_clock_port uut (
    .clk(clk), .rst_n(rst_n), .cs_in_n(cs_in_n), .oe_n(oe_n), .we_n(we_n),
    .din(din), .rst_in_n(rst_in_n), .power_fail(power_fail), .time_in(time_in),
    .ce_out_n(ce_out_n), .dout(dout), .dout_valid(dout_valid),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare produced beats with the scoreboard
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (exp_wr.size() == 0) check(1'b0, "R5/R10 unexpected commit", {wr_idx, wr_data}, 0);
      else begin
        logic [10:0] e;
        e = exp_wr.pop_front();
        check({wr_idx, wr_data} == e, "R5 commit", {wr_idx, wr_data}, e);
      end
    end
    if (rst_n && dout_valid) begin
      if (exp_rd.size() == 0) check(1'b0, "R6 unexpected read bit", dout, 0);
      else begin
        logic e;
        e = exp_rd.pop_front();
        check(dout == e, "R6 read bit", dout, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // one bus access: kind 0=read 1=write; sel=1 means chip enable in low
  task automatic access(input bit wr, input bit b, input bit sel, input bit exp_ce, input string req);
    @(negedge clk);
    cs_in_n = ~sel; we_n = ~wr; oe_n = wr; din = b;
    @(negedge clk);
    check(ce_out_n == exp_ce, req, ce_out_n, exp_ce);
    @(negedge clk);
    cs_in_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_key(input bit interleave);
    access(1'b0, 1'b0, 1'b1, 1'b0, "R1 unlock read to memory");
    for (int i = 0; i < 64; i++) begin
      if (interleave && (i % 8 == 3)) access(1'b1, 1'b1, 1'b0, 1'b1, "R7 deselected write");
      access(1'b1, KEY[i], 1'b1, 1'b0, "R1 key write to memory");
    end
  endtask

  task automatic write_bits(input logic [63:0] d, input int from, input int upto, input bit interleave);
    for (int i = from; i < upto; i++) begin
      if (interleave && (i % 8 == 5)) access(1'b0, 1'b0, 1'b0, 1'b1, "R7 deselected read");
      access(1'b1, d[i], 1'b1, 1'b1, "R4 memory held off");
    end
  endtask

  task automatic expect_bytes(input logic [63:0] d, input int first, input int last);
    for (int k = first; k <= last; k++) exp_wr.push_back({3'(k), d[8*k +: 8]});
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_in_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_in_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [63:0] d;
    logic [63:0] snap_v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ce_out_n == 1'b1, "R1 reset idle ce", ce_out_n, 1);
    check(wr_valid == 1'b0 && dout_valid == 1'b0, "R5 reset no beats", {wr_valid, dout_valid}, 0);

    // plain memory traffic
    access(1'b0, 1'b0, 1'b1, 1'b0, "R1 memory read");
    access(1'b1, 1'b1, 1'b1, 1'b0, "R1 memory write");

    // full write transfer
    d = 64'h0123_4567_89AB_CDEF;
    send_key(1'b0);
    expect_bytes(d, 0, 7);
    write_bits(d, 0, 64, 1'b0);
    access(1'b1, 1'b0, 1'b1, 1'b0, "R11 relocked after 64");
    access(1'b0, 1'b0, 1'b1, 1'b0, "R11 still locked");

    // read transfer with snapshot
    snap_v = 64'hA5C3_1E77_0F99_4D28;
    time_in = snap_v;
    send_key(1'b0);
    time_in = 64'h0;
    for (int i = 0; i < 64; i++) begin
      exp_rd.push_back(snap_v[i]);
      access(1'b0, 1'b0, 1'b1, 1'b1, "R6 read held off memory");
    end
    access(1'b0, 1'b0, 1'b1, 1'b0, "R11 relocked after reads");

    // mismatch freezes: wrong bit 10, rest correct
    access(1'b0, 1'b0, 1'b1, 1'b0, "R3 read");
    for (int i = 0; i < 64; i++)
      access(1'b1, (i == 10) ? ~KEY[i] : KEY[i], 1'b1, 1'b0, "R3 key write");
    access(1'b1, 1'b1, 1'b1, 1'b0, "R3 still locked after bad bit");

    // read mid-key rewinds the pointer
    for (int i = 0; i < 20; i++) access(1'b1, KEY[i], 1'b1, 1'b0, "R2 partial key");
    d = 64'hFEDC_BA98_7654_3210;
    send_key(1'b0);
    expect_bytes(d, 0, 7);
    write_bits(d, 0, 64, 1'b0);
    check(exp_wr.size() == 0, "R2 unlock after rewind", exp_wr.size(), 0);

    // deselected activity interleaved everywhere
    d = 64'h3C5A_9612_E0F1_7B44;
    send_key(1'b1);
    expect_bytes(d, 0, 7);
    write_bits(d, 0, 64, 1'b1);
    access(1'b1, 1'b0, 1'b1, 1'b0, "R7 relocked after interleaved");

    // reset abort, mask clear: byte 0 kept, partial byte 1 dropped
    time_in = 64'h0;
    d = 64'h0000_0000_0000_5A96;
    send_key(1'b0);
    expect_bytes(d, 0, 0);
    write_bits(d, 0, 12, 1'b0);
    pulse_reset();
    access(1'b1, 1'b0, 1'b1, 1'b0, "R8 reset aborted transfer");
    check(exp_wr.size() == 0, "R10 partial byte dropped", exp_wr.size(), 0);

    // reset masked: transfer survives
    time_in = 64'h0000_0010_0000_0000;
    d = 64'h7E81_24DB_66C3_18E7;
    send_key(1'b0);
    expect_bytes(d, 0, 7);
    write_bits(d, 0, 4, 1'b0);
    pulse_reset();
    write_bits(d, 4, 64, 1'b0);
    access(1'b0, 1'b0, 1'b1, 1'b0, "R8 masked reset ignored");
    time_in = 64'h0;

    // power fail abort
    send_key(1'b0);
    write_bits(64'h1F, 0, 5, 1'b0);
    @(negedge clk); power_fail = 1'b1;
    access(1'b1, 1'b1, 1'b1, 1'b1, "R9 ce forced high");
    access(1'b0, 1'b0, 1'b1, 1'b1, "R9 ce forced high on read");
    @(negedge clk); power_fail = 1'b0;
    access(1'b1, 1'b1, 1'b1, 1'b0, "R9 locked after power fail");
    check(exp_wr.size() == 0, "R9 no commit after power fail", exp_wr.size(), 0);

    // mixed byte 0 is not committed
    snap_v = 64'h1122_3344_5566_77B8;
    time_in = snap_v;
    d = 64'hCAFE_F00D_BEEF_1200;
    send_key(1'b0);
    write_bits(d, 0, 4, 1'b0);
    for (int i = 4; i < 8; i++) begin
      exp_rd.push_back(snap_v[i]);
      access(1'b0, 1'b0, 1'b1, 1'b1, "R10 mixed byte read");
    end
    expect_bytes(d, 1, 7);
    write_bits(d, 8, 64, 1'b0);
    time_in = 64'h0;

    repeat (8) @(negedge clk);
    check(exp_wr.size() == 0, "R5 all commits seen", exp_wr.size(), 0);
    check(exp_rd.size() == 0, "R6 all read bits seen", exp_rd.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule